// File: doc/BRIEF.md
# HDLC Interrupt Status and Mask

This block gathers single-cycle event pulses from an HDLC controller into an eight-bit sticky status register. It combines that register with a writable eight-bit enable mask to produce one active-low interrupt request. Status bits latch whether or not they are enabled. The mask only decides which latched bits may pull the request pin low.

Nine event sources share the eight status bits. The frame-abort event and the transmit-underrun event both map to status bit 2. A control bit chooses which of the two is latched there. The host uses a small synchronous register bus to read status (the read clears it), to read and write the mask, and to read and write the control bit.

Top module: `hdlc_irq_ctrl`

## Requirements
- R1: After reset the status, mask and control registers are all zero, and `irq_n` is high.
- R2: A one-cycle event pulse sets its status bit at the next clock edge. The bit positions are: 0 go-ahead, 1 transmit FIFO low, 2 shared abort/underrun, 3 receive FIFO full, 4 receive FIFO nearly full, 5 transmit end-of-packet, 6 receive overflow, 7 receive end-of-packet.
- R3: A status bit that is set stays set, across any number of idle cycles, until the status register is read.
- R4: A read of address 0 returns the status on `bus_rdata` one cycle later and clears every status bit at the same edge. An event that arrives in the cycle of the read stays set after the read.
- R5: An event whose mask bit is 0 still sets its status bit, and `irq_n` stays high.
- R6: `irq_n` is low exactly when some status bit and its mask bit are both 1. A write to the mask at address 1 takes effect on `irq_n` right after the write edge.
- R7: Control bit 0 (address 2) selects the source for status bit 2. When it is 1, bit 2 latches transmit underrun and abort pulses are ignored. When it is 0, bit 2 latches frame abort and underrun pulses are ignored.
- R8: Address 1 reads back the mask. Address 2 reads back the control bit in bit 0, with zeros in bits 7..1.
- R9: A read of address 3 returns zero. Writes to address 0 or address 3 change nothing. `bus_rdata` is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_go_ahead | input | 1 | Go-ahead event pulse |
| ev_rx_eop | input | 1 | Receive end-of-packet pulse |
| ev_rx_ovf | input | 1 | Receive overflow pulse |
| ev_tx_eop | input | 1 | Transmit end-of-packet pulse |
| ev_rx_full | input | 1 | Receive FIFO full pulse |
| ev_rx_near | input | 1 | Receive FIFO nearly full pulse |
| ev_tx_low | input | 1 | Transmit FIFO low pulse |
| ev_abort | input | 1 | Received frame abort pulse |
| ev_tx_under | input | 1 | Transmit underrun pulse |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Each event source is pulsed on its own so that a misplaced status bit shows up. All sources are then pulsed together with every bit masked, which separates latching from request generation. Abort and underrun are pulsed under both settings of the control bit, which shows whether the unselected source is dropped. Directed cases cover a read that coincides with an event and a mask write over an already latched bit. Seeded random traffic then mixes events, reads, writes and addresses against a bench model, which exposes ordering errors between clear, latch and mask.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
  localparam int NBITS  = 8;
  localparam int ADDR_W = 2;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [NBITS-1:0]  vec_t;
  localparam addr_t A_STAT = 2'd0;
  localparam addr_t A_MASK = 2'd1;
  localparam addr_t A_CTRL = 2'd2;
  localparam int B_GO     = 0;
  localparam int B_TXLOW  = 1;
  localparam int B_SHARED = 2;
  localparam int B_RXFULL = 3;
  localparam int B_RXNEAR = 4;
  localparam int B_TXEOP  = 5;
  localparam int B_RXOVF  = 6;
  localparam int B_RXEOP  = 7;
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
  import hdlc_irq_pkg::*;
(
  input  logic ev_go_ahead,
  input  logic ev_rx_eop,
  input  logic ev_rx_ovf,
  input  logic ev_tx_eop,
  input  logic ev_rx_full,
  input  logic ev_rx_near,
  input  logic ev_tx_low,
  input  logic ev_abort,
  input  logic ev_tx_under,
  input  logic sel_under,
  output vec_t ev_vec
);
  always_comb begin
    ev_vec           = '0;
    ev_vec[B_GO]     = ev_go_ahead;
    ev_vec[B_TXLOW]  = ev_tx_low;
    ev_vec[B_SHARED] = sel_under ? ev_tx_under : ev_abort;
    ev_vec[B_RXFULL] = ev_rx_full;
    ev_vec[B_RXNEAR] = ev_rx_near;
    ev_vec[B_TXEOP]  = ev_tx_eop;
    ev_vec[B_RXOVF]  = ev_rx_ovf;
    ev_vec[B_RXEOP]  = ev_rx_eop;
  end
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky
  import hdlc_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  vec_t ev_vec,
  input  logic clr,
  output vec_t status_q
);
  vec_t status_d;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_comb status_d[i] = (clr ? 1'b0 : status_q[i]) | ev_vec[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= status_d[i];
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import hdlc_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  addr_t addr,
  input  vec_t  wdata,
  output vec_t  mask_q,
  output logic  sel_q
);
  vec_t mask_d;
  logic sel_d;
  logic mask_en, ctrl_en;

  always_comb begin
    mask_en = wr && (addr == A_MASK);
    ctrl_en = wr && (addr == A_CTRL);
    mask_d  = mask_en ? wdata    : mask_q;
    sel_d   = ctrl_en ? wdata[0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/hdlc_irq_ctrl.sv
module hdlc_irq_ctrl
  import hdlc_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_go_ahead,
  input  logic       ev_rx_eop,
  input  logic       ev_rx_ovf,
  input  logic       ev_tx_eop,
  input  logic       ev_rx_full,
  input  logic       ev_rx_near,
  input  logic       ev_tx_low,
  input  logic       ev_abort,
  input  logic       ev_tx_under,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_n
);
  vec_t ev_vec, status_q, mask_q, rdata_d;
  logic sel_q, rd_stat;

  irq_src_map u_map (
    .ev_go_ahead(ev_go_ahead), .ev_rx_eop(ev_rx_eop), .ev_rx_ovf(ev_rx_ovf),
    .ev_tx_eop(ev_tx_eop), .ev_rx_full(ev_rx_full), .ev_rx_near(ev_rx_near),
    .ev_tx_low(ev_tx_low), .ev_abort(ev_abort), .ev_tx_under(ev_tx_under),
    .sel_under(sel_q), .ev_vec(ev_vec)
  );

  irq_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec), .clr(rd_stat), .status_q(status_q)
  );

  irq_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mask_q(mask_q), .sel_q(sel_q)
  );

  always_comb begin
    rd_stat = bus_rd && (bus_addr == A_STAT);
    rdata_d = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_STAT:  rdata_d = status_q;
        A_MASK:  rdata_d = mask_q;
        A_CTRL:  rdata_d = {{(NBITS-1){1'b0}}, sel_q};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rdata_d;
  end

  always_comb irq_n = ~|(status_q & mask_q);
endmodule

// File: rtl/hdlc_irq_chk.sv
module hdlc_irq_chk
  import hdlc_irq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       irq_n,
  input vec_t       ev_vec,
  input vec_t       status_q,
  input vec_t       mask_q
);
  // R2
  ev_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(ev_vec)) == $past(ev_vec)));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == A_STAT) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STAT) |=> (status_q == $past(ev_vec)));

  // R4
  read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STAT) |=> (bus_rdata == $past(status_q)));

  // R6
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & mask_q)) |-> !irq_n);

  // R6
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK) |=> (mask_q == $past(bus_wdata)));

  // R9
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3) |=> (bus_rdata == 8'h00));

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == 8'h00));
endmodule

bind hdlc_irq_ctrl hdlc_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_n(irq_n), .ev_vec(ev_vec), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/hdlc_irq_ctrl_test.sv
`timescale 1ns/1ps
module hdlc_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [8:0] ev;
  logic [1:0] bus_addr;
  logic bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic irq_n;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] m_stat, m_mask, m_rdata;
  logic       m_sel;

  always #4 clk = ~clk;

  hdlc_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .ev_go_ahead(ev[0]), .ev_rx_eop(ev[1]), .ev_rx_ovf(ev[2]), .ev_tx_eop(ev[3]),
    .ev_rx_full(ev[4]), .ev_rx_near(ev[5]), .ev_tx_low(ev[6]), .ev_abort(ev[7]),
    .ev_tx_under(ev[8]), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  // ev index: 0 go,1 rx_eop,2 rx_ovf,3 tx_eop,4 rx_full,5 rx_near,6 tx_low,7 abort,8 under
  function automatic logic [7:0] map_ev(input logic [8:0] e, input logic sel);
    logic [7:0] v;
    v[0] = e[0]; v[1] = e[6]; v[2] = sel ? e[8] : e[7]; v[3] = e[4];
    v[4] = e[5]; v[5] = e[3]; v[6] = e[2]; v[7] = e[1];
    return v;
  endfunction

  function automatic logic [7:0] read_val(input logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return m_mask;
      2'd2: return {7'b0, m_sel};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // called at a negedge; drives one cycle and checks at the next negedge
  task automatic cyc(input logic [8:0] e, input logic rd, input logic wr,
                     input logic [1:0] a, input logic [7:0] wd, input string tag);
    logic [7:0] nxt_stat;
    ev = e; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    m_rdata  = rd ? read_val(a) : 8'h00;
    nxt_stat = ((rd && a == 2'd0) ? 8'h00 : m_stat) | map_ev(e, m_sel);
    if (wr && a == 2'd1) m_mask = wd;
    if (wr && a == 2'd2) m_sel = wd[0];
    m_stat = nxt_stat;
    @(posedge clk);
    @(negedge clk);
    ev = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    check(tag, "rdata", bus_rdata, m_rdata);
    check(tag, "irq_n", {7'b0, irq_n}, {7'b0, ~|(m_stat & m_mask)});
  endtask

  task automatic idle(input string tag);
    cyc(9'h0, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc(9'h0, 1'b1, 1'b0, a, 8'h00, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    cyc(9'h0, 1'b0, 1'b1, a, d, tag);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd7;
    void'($urandom(seed));
    rst_n = 1'b0; ev = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_stat = '0; m_mask = '0; m_sel = 1'b0; m_rdata = '0;
    repeat (3) @(negedge clk);
    check("R1", "irq_n in reset", {7'b0, irq_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");
    // R5 masked events latch without irq
    cyc(9'h1FF, 1'b0, 1'b0, 2'd0, 8'h00, "R5");
    rd(2'd0, "R5");
    rd(2'd0, "R4");
    // R2 each source alone
    for (int i = 0; i < 8; i++) begin
      cyc(9'(1 << i), 1'b0, 1'b0, 2'd0, 8'h00, "R2");
      rd(2'd0, "R2");
    end
    // R3 sticky across idle cycles
    cyc(9'h002, 1'b0, 1'b0, 2'd0, 8'h00, "R3");
    repeat (5) idle("R3");
    rd(2'd0, "R3");
    // R4 event during read survives
    cyc(9'h001, 1'b0, 1'b0, 2'd0, 8'h00, "R4");
    cyc(9'h010, 1'b1, 1'b0, 2'd0, 8'h00, "R4");
    rd(2'd0, "R4");
    // R6 mask write over latched bit
    cyc(9'h040, 1'b0, 1'b0, 2'd0, 8'h00, "R6");
    wr(2'd1, 8'h02, "R6");
    wr(2'd1, 8'h00, "R6");
    rd(2'd0, "R6");
    // R7 source selection for bit 2
    wr(2'd1, 8'h04, "R7");
    cyc(9'h100, 1'b0, 1'b0, 2'd0, 8'h00, "R7");
    cyc(9'h080, 1'b0, 1'b0, 2'd0, 8'h00, "R7");
    rd(2'd0, "R7");
    wr(2'd2, 8'hFF, "R7");
    rd(2'd2, "R8");
    cyc(9'h080, 1'b0, 1'b0, 2'd0, 8'h00, "R7");
    cyc(9'h100, 1'b0, 1'b0, 2'd0, 8'h00, "R7");
    rd(2'd0, "R7");
    // R8 readback
    wr(2'd1, 8'hA5, "R8");
    rd(2'd1, "R8");
    // R9 unimplemented and read-only addresses
    cyc(9'h001, 1'b0, 1'b0, 2'd0, 8'h00, "R9");
    wr(2'd0, 8'h00, "R9");
    wr(2'd3, 8'hFF, "R9");
    rd(2'd3, "R9");
    rd(2'd0, "R9");
    rd(2'd1, "R9");
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [8:0] e;
      logic r, w;
      e = ($urandom % 4 == 0) ? 9'($urandom) : 9'h0;
      r = ($urandom % 3 == 0);
      w = ($urandom % 5 == 0);
      cyc(e, r, w, 2'($urandom), 8'($urandom), "R2,R4,R6,R7");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule